// File: doc/BRIEF.md
# Shadowed Double-Edge PWM Timer

This block is a pulse-width modulation timer for a large chip's peripheral fabric. A 32-bit prescaler divides the clock into timer ticks, and a 32-bit counter advances once per tick. A bank of compare values sets the period, which all outputs share. It also sets the turn-on and turn-off points of each output. Any output from the second one upward may be switched from single-edge to double-edge operation, and any output may have its level inverted.

Compare values are never written straight into the comparators while modulation is on. Software writes a shadow copy and then marks it as released in a release mask. The shadow copy reaches the comparator only at the tick that ends the current period, so no output can see half of an update or a truncated pulse. With modulation off, the block is a free-running counter. Compare writes then apply at once, and a sticky flag records each compare hit.

A small run-control state machine governs the counter. It has three states. ST_HALT freezes the counter and the prescaler. ST_RUN lets them count. ST_CLEAR holds both at zero. The transitions are evaluated every cycle from the control register, and clear wins over run:
- HALT_TO_RUN: run set, clear not set.
- HALT_TO_CLEAR and RUN_TO_CLEAR: clear set.
- RUN_TO_HALT: run dropped.
- CLEAR_TO_RUN: clear dropped, run set.
- CLEAR_TO_HALT: clear dropped, run not set.

Top module: `pwm_shadow_timer`

## Requirements
- R1: With prescale value P, the counter advances by exactly one every P+1 clocks while in ST_RUN. A prescale of 0 gives one advance per clock.
- R2: In modulation mode (control bit 1), the counter counts 0, 1, …, M0 and then returns to 0 on the next tick. M0 is the active compare 0, so the period is M0+1 ticks.
- R3: In single-edge mode, output n (n = 1..3) is high while the counter is below active compare Mn. It follows the counter one clock later. Mn = 0 keeps the output low, and Mn > M0 keeps it high.
- R4: When bit n of the double-edge register (address 3) is set, for n ≥ 2, output n is high while Mn-1 ≤ counter < Mn. Bit 1 of that register is ignored.
- R5: Bit n of the polarity register (address 4) inverts output n in either edge mode.
- R6: In modulation mode, a write to compare k (address 8+k) changes only the shadow copy. Reading address 8+k returns the active value, which is unchanged, and the outputs keep the old timing.
- R7: Released compare values become active together at the tick where the counter equals the old M0. The counter then restarts at 0 under the new values.
- R8: Writing a mask to address 2 ORs it into the pending-release bits, one bit per compare, which are read back at the same address. Every pending bit clears on its own when its transfer takes place.
- R9: With control bit 1 clear (timer mode), all outputs are low. The counter does not return to 0 at M0, and compare writes become active at once.
- R10: Flag bit k (address 6) is set at any tick where the counter equals Mk. Writing 1 to a flag bit clears it.
- R11: Control bit 2 (clear) holds the counter and the prescaler at 0. With control bit 0 (run) low, the counter holds its value.
- R12: After reset, all registers, the counter, the pending bits, the flags and the outputs are 0, and the machine is in ST_HALT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | CNT_W | Read data (combinational); counter at address 5 |
| pwm_out | output | NUM_MATCH-1 | PWM outputs; bit n is output n |

## Verification
A wrong counter or a wrong wrap point shows up as a bad counter readback within one clock, and as a shifted output edge one clock after that. A transfer that happens at the wrong moment shows at the ports in two ways. The active compare readback changes while the counter is mid-period, and an output edge moves before the boundary. Both appear within one period of the release. A pending bit that fails to clear stays visible at address 2 after the wrap. A stale shadow copy produces output widths that do not match the arithmetic model from the first new period onward.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_CLEAR = 2'd1,
        ST_RUN   = 2'd2
    } run_state_t;

    localparam int unsigned REG_CTRL     = 0;
    localparam int unsigned REG_PRESCALE = 1;
    localparam int unsigned REG_RELEASE  = 2;
    localparam int unsigned REG_DOUBLE   = 3;
    localparam int unsigned REG_POLARITY = 4;
    localparam int unsigned REG_COUNT    = 5;
    localparam int unsigned REG_FLAGS    = 6;
    localparam int unsigned REG_MATCH0   = 8;

    localparam int unsigned CTL_RUN = 0;
    localparam int unsigned CTL_PWM = 1;
    localparam int unsigned CTL_CLR = 2;
    localparam int unsigned CTL_W   = 3;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);
    logic [CNT_W-1:0] pc_q;

    always_comb begin
        tick = run && (pc_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (clear) begin
            pc_q <= '0;
        end else if (run) begin
            pc_q <= tick ? '0 : pc_q + CNT_W'(1);
        end
    end

    // R1: a tick restarts the prescale count
    assert_tick_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear) |=> (pc_q == '0));

    // R1: between ticks the prescale count steps by one
    assert_pc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !clear) |=> (pc_q == $past(pc_q) + CNT_W'(1)));

    // R11: clear holds the prescaler at zero
    assert_pc_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pc_q == '0));

endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned NUM_MATCH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_MATCH-1:0]         wr_sel,
    input  logic [CNT_W-1:0]             wr_data,
    input  logic                         direct,
    input  logic [NUM_MATCH-1:0]         release_set,
    input  logic                         boundary,
    output logic [NUM_MATCH*CNT_W-1:0]   active_flat,
    output logic [NUM_MATCH-1:0]         pending
);
    logic [NUM_MATCH-1:0] xfer;

    always_comb begin
        xfer = boundary ? pending : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= '0;
        end else begin
            pending <= (pending & ~xfer) | release_set;
        end
    end

    for (genvar k = 0; k < NUM_MATCH; k++) begin : g_slot
        logic [CNT_W-1:0] shadow_q;
        logic [CNT_W-1:0] active_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q <= '0;
            end else if (wr_sel[k]) begin
                shadow_q <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                active_q <= '0;
            end else if (direct && wr_sel[k]) begin
                active_q <= wr_data;
            end else if (xfer[k]) begin
                active_q <= shadow_q;
            end
        end

        assign active_flat[k*CNT_W +: CNT_W] = active_q;
    end

    // R8: pending bits drop at the boundary unless re-armed in that cycle
    assert_pending_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && (release_set == '0)) |=> (pending == '0));

    // R6/R7: active values move only at a boundary or a direct write
    assert_active_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && !(direct && (wr_sel != '0))) |=> $stable(active_flat));

    // R6: a write in modulation mode leaves the active copy unchanged
    assert_shadow_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct && !boundary && (wr_sel != '0)) |=> $stable(active_flat));

endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned ALLOW_DBL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] lo,
    input  logic [CNT_W-1:0] hi,
    input  logic             dbl,
    input  logic             pol,
    output logic             out
);
    logic dbl_eff;
    logic level;

    always_comb begin
        dbl_eff = (ALLOW_DBL != 0) && dbl;
        if (dbl_eff) begin
            level = (count >= lo) && (count < hi);
        end else begin
            level = (count < hi);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out <= 1'b0;
        end else begin
            out <= en ? (level ^ pol) : 1'b0;
        end
    end

    // R3: single-edge output is high at counter zero when its compare is nonzero
    assert_zero_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !dbl_eff && !pol && (count == '0) && (hi != '0)) |=> out);

    // R3/R4: at or past the clearing compare a non-inverted output is low
    assert_past_hi_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !pol && (count >= hi)) |=> !out);

    // R9: timer mode keeps the output low
    assert_timer_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !out);

endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
    import pwm_shadow_pkg::*;
#(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned NUM_MATCH = 4,
    parameter int unsigned ADDR_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CNT_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [CNT_W-1:0]     rd_data,
    output logic [NUM_MATCH-1:1] pwm_out
);
    localparam int unsigned FLAG_W = NUM_MATCH;

    run_state_t state_q, state_nx;

    logic [CTL_W-1:0]         ctrl_q;
    logic [CNT_W-1:0]         prescale_q;
    logic [NUM_MATCH-1:0]     dbl_q;
    logic [NUM_MATCH-1:0]     pol_q;
    logic [FLAG_W-1:0]        flags_q;
    logic [CNT_W-1:0]         tc_q;

    logic                     run_en;
    logic                     clr_en;
    logic                     tick;
    logic                     pwm_mode;
    logic                     boundary;
    logic [NUM_MATCH-1:0]     wr_sel;
    logic [NUM_MATCH-1:0]     release_set;
    logic [NUM_MATCH-1:0]     pending;
    logic [NUM_MATCH*CNT_W-1:0] active_flat;
    logic [FLAG_W-1:0]        hit;
    logic [FLAG_W-1:0]        flag_clr;

    // ---------------- run-control state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (ctrl_q[CTL_CLR])      state_nx = ST_CLEAR;
                else if (ctrl_q[CTL_RUN]) state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (ctrl_q[CTL_CLR])       state_nx = ST_CLEAR;
                else if (!ctrl_q[CTL_RUN]) state_nx = ST_HALT;
            end
            ST_CLEAR: begin
                if (!ctrl_q[CTL_CLR]) state_nx = ctrl_q[CTL_RUN] ? ST_RUN : ST_HALT;
            end
            default: state_nx = ST_HALT;
        endcase
    end

    // ---------------- state outputs
    always_comb begin
        run_en = 1'b0;
        clr_en = 1'b0;
        unique case (state_q)
            ST_HALT:  ;
            ST_RUN:   run_en = 1'b1;
            ST_CLEAR: clr_en = 1'b1;
            default:  ;
        endcase
    end

    // ---------------- write decode
    always_comb begin
        pwm_mode    = ctrl_q[CTL_PWM];
        release_set = (wr_en && (wr_addr == ADDR_W'(REG_RELEASE))) ? wr_data[NUM_MATCH-1:0] : '0;
        flag_clr    = (wr_en && (wr_addr == ADDR_W'(REG_FLAGS))) ? wr_data[FLAG_W-1:0] : '0;
        for (int k = 0; k < NUM_MATCH; k++) begin
            wr_sel[k] = wr_en && (wr_addr == ADDR_W'(REG_MATCH0 + k));
            hit[k]    = tick && (tc_q == active_flat[k*CNT_W +: CNT_W]);
        end
        boundary = tick && pwm_mode && (tc_q == active_flat[0 +: CNT_W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            prescale_q <= '0;
            dbl_q      <= '0;
            pol_q      <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(REG_CTRL))     ctrl_q     <= wr_data[CTL_W-1:0];
            if (wr_addr == ADDR_W'(REG_PRESCALE)) prescale_q <= wr_data;
            if (wr_addr == ADDR_W'(REG_DOUBLE))   dbl_q      <= wr_data[NUM_MATCH-1:0];
            if (wr_addr == ADDR_W'(REG_POLARITY)) pol_q      <= wr_data[NUM_MATCH-1:0];
        end
    end

    // ---------------- counter and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_q <= '0;
        end else if (clr_en) begin
            tc_q <= '0;
        end else if (tick) begin
            tc_q <= boundary ? '0 : tc_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~flag_clr) | hit;
        end
    end

    // ---------------- sub-blocks
    pwm_prescaler #(.CNT_W(CNT_W)) u_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_en),
        .clear (clr_en),
        .limit (prescale_q),
        .tick  (tick)
    );

    pwm_match_bank #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_match_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .direct      (!pwm_mode),
        .release_set (release_set),
        .boundary    (boundary),
        .active_flat (active_flat),
        .pending     (pending)
    );

    for (genvar n = 1; n < NUM_MATCH; n++) begin : g_out
        pwm_edge_gen #(.CNT_W(CNT_W), .ALLOW_DBL((n >= 2) ? 1 : 0)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (pwm_mode),
            .count (tc_q),
            .lo    (active_flat[(n-1)*CNT_W +: CNT_W]),
            .hi    (active_flat[n*CNT_W +: CNT_W]),
            .dbl   (dbl_q[n]),
            .pol   (pol_q[n]),
            .out   (pwm_out[n])
        );
    end

    // ---------------- read mux
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(REG_CTRL))     rd_data = CNT_W'(ctrl_q);
        if (rd_addr == ADDR_W'(REG_PRESCALE)) rd_data = prescale_q;
        if (rd_addr == ADDR_W'(REG_RELEASE))  rd_data = CNT_W'(pending);
        if (rd_addr == ADDR_W'(REG_DOUBLE))   rd_data = CNT_W'(dbl_q);
        if (rd_addr == ADDR_W'(REG_POLARITY)) rd_data = CNT_W'(pol_q);
        if (rd_addr == ADDR_W'(REG_COUNT))    rd_data = tc_q;
        if (rd_addr == ADDR_W'(REG_FLAGS))    rd_data = CNT_W'(flags_q);
        for (int k = 0; k < NUM_MATCH; k++) begin
            if (rd_addr == ADDR_W'(REG_MATCH0 + k)) rd_data = active_flat[k*CNT_W +: CNT_W];
        end
    end

    // ---------------- assertions
    // R2: the tick at the period compare restarts the counter
    assert_period_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !clr_en) |=> (tc_q == '0));

    // R1: an ordinary tick advances the counter by one
    assert_tc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !boundary) |=> (tc_q == $past(tc_q) + CNT_W'(1)));

    // R11: clear state zeroes the counter
    assert_clear_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (tc_q == '0));

    // R11: halted counter holds
    assert_halt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> $stable(tc_q));

    // R11: only legal states, clear has priority
    assert_state_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CTL_CLR] |=> (state_q == ST_CLEAR));

    // R10: a hit sets its flag on the next cycle
    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((flags_q & $past(hit)) == $past(hit)));

endmodule

// File: tb/pwm_shadow_timer_bench.sv
`timescale 1ns/100ps
module pwm_shadow_timer_bench;

    localparam int unsigned CNT_W  = 32;
    localparam int unsigned NM     = 4;
    localparam int unsigned ADDR_W = 4;

    localparam logic [3:0] A_CTRL = 4'd0, A_PRE = 4'd1, A_REL = 4'd2, A_DBL = 4'd3,
                           A_POL = 4'd4, A_CNT = 4'd5, A_FLG = 4'd6, A_M0 = 4'd8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = A_CNT;
    logic [CNT_W-1:0]  rd_data;
    logic [NM-1:1]     pwm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] act_m [NM];
    logic [NM-1:0] dbl_m = '0;
    logic [NM-1:0] pol_m = '0;

    always #2 clk = ~clk;

    pwm_shadow_timer #(.CNT_W(CNT_W), .NUM_MATCH(NM), .ADDR_W(ADDR_W)) u_pwm_shadow_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #0.1;
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.1;
        d = rd_data;
    endtask

    function automatic logic exp_bit(input int n, input logic [31:0] t);
        logic lvl;
        if (n >= 2 && dbl_m[n]) lvl = (t >= act_m[n-1]) && (t < act_m[n]);
        else                    lvl = (t < act_m[n]);
        return lvl ^ pol_m[n];
    endfunction

    // release mask, then wait for the pending bits to clear
    task automatic release_wait(input logic [3:0] mask);
        logic [31:0] v;
        bus_write(A_REL, {28'd0, mask});
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            bus_read(A_REL, v);
            if (v == 0) break;
        end
        check(v == 0, "R8 pending cleared after transfer", v, 0);
    endtask

    // per-cycle check of counter sequence (prescale 0) and outputs
    task automatic run_check(input int ncyc);
        logic [31:0] prev, now, etc;
        logic [NM-1:1] eo;
        string tag;
        @(negedge clk);
        bus_read(A_CNT, prev);
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            bus_read(A_CNT, now);
            etc = (prev == act_m[0]) ? 32'd0 : prev + 32'd1;
            check(now == etc, "R2 counter sequence", now, etc);
            for (int n = 1; n < NM; n++) eo[n] = exp_bit(n, prev);
            if (pol_m != 0)      tag = "R5 polarity output";
            else if (dbl_m != 0) tag = "R4 double-edge output";
            else                 tag = "R3 single-edge output";
            check(pwm_out == eo, tag, {29'd0, pwm_out}, {29'd0, eo});
            prev = now;
        end
    endtask

    initial begin
        #(4.0 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2, prev, now;
        int last_chg, intervals;
        bit seen_top;

        for (int k = 0; k < NM; k++) act_m[k] = 0;
        #10;
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        bus_read(A_CTRL, v); check(v == 0, "R12 ctrl reset", v, 0);
        bus_read(A_CNT, v);  check(v == 0, "R12 counter reset", v, 0);
        bus_read(A_REL, v);  check(v == 0, "R12 pending reset", v, 0);
        bus_read(A_FLG, v);  check(v == 0, "R12 flags reset", v, 0);
        bus_read(A_M0 + 4'd1, v); check(v == 0, "R12 compare reset", v, 0);
        check(pwm_out == 0, "R12 outputs reset", {29'd0, pwm_out}, 0);
        repeat (3) @(negedge clk);
        bus_read(A_CNT, v);  check(v == 0, "R12 halted after reset", v, 0);

        // modulation mode, prescale 0
        bus_write(A_PRE, 0);
        bus_write(A_CTRL, 32'd3);

        // R3/R4/R5/R2 sweep
        for (int p = 2; p <= 6; p += 2) begin
            for (int m1 = 0; m1 <= p + 1; m1++) begin
                for (int cfg = 0; cfg < 4; cfg++) begin
                    logic [31:0] m2, m3;
                    m2 = (m1 + 1) % (p + 2);
                    m3 = (2 * m1 + 1) % (p + 2);
                    dbl_m = cfg[0] ? 4'b1110 : 4'b0000;
                    pol_m = cfg[1] ? 4'b1010 : 4'b0000;
                    bus_write(A_DBL, {28'd0, dbl_m});
                    bus_write(A_POL, {28'd0, pol_m});
                    bus_write(A_M0, p);
                    bus_write(A_M0 + 4'd1, m1);
                    bus_write(A_M0 + 4'd2, m2);
                    bus_write(A_M0 + 4'd3, m3);
                    release_wait(4'hF);
                    act_m[0] = p; act_m[1] = m1; act_m[2] = m2; act_m[3] = m3;
                    run_check(2 * (p + 1) + 3);
                end
            end
        end

        // R6/R7/R8 with old period 5
        dbl_m = 0; pol_m = 0;
        bus_write(A_DBL, 0);
        bus_write(A_POL, 0);
        bus_write(A_M0, 5);
        bus_write(A_M0 + 4'd1, 3);
        release_wait(4'b0011);
        act_m[0] = 5; act_m[1] = 3;
        bus_write(A_M0, 3);
        bus_write(A_M0 + 4'd1, 2);
        run_check(14);   // R6: outputs keep the old timing without release
        bus_read(A_M0, v);        check(v == 5, "R6 active compare 0 unchanged", v, 5);
        bus_read(A_M0 + 4'd1, v); check(v == 3, "R6 active compare 1 unchanged", v, 3);
        bus_write(A_REL, 32'h3);
        bus_read(A_REL, v);       check(v == 3, "R8 pending bits visible", v, 3);
        bus_read(A_CNT, prev);
        seen_top = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            bus_read(A_M0 + 4'd1, v);
            bus_read(A_CNT, now);
            if (prev == 5 && now == 0) begin
                check(v == 2, "R7 new value active at boundary", v, 2);
                seen_top = 1'b1;
                break;
            end else begin
                check(v == 3, "R7 old value kept mid-period", v, 3);
            end
            prev = now;
        end
        check(seen_top, "R7 old period completed before transfer", {31'd0, seen_top}, 1);
        bus_read(A_REL, v); check(v == 0, "R8 pending self-cleared", v, 0);
        act_m[0] = 3; act_m[1] = 2;
        run_check(10);

        // R1: prescale 2
        bus_write(A_PRE, 2);
        bus_write(A_M0, 1000);
        release_wait(4'b0001);
        bus_read(A_CNT, prev);
        last_chg = -1; intervals = 0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            bus_read(A_CNT, now);
            if (now != prev) begin
                check(now == prev + 1, "R1 step of one", now, prev + 1);
                if (last_chg >= 0) begin
                    check(c - last_chg == 3, "R1 tick interval", c - last_chg, 3);
                    intervals++;
                end
                last_chg = c;
            end
            prev = now;
        end
        check(intervals >= 10, "R1 ticks observed", intervals, 10);

        // R11: halt holds, clear zeroes
        bus_write(A_CTRL, 32'd2);
        repeat (2) @(negedge clk);
        bus_read(A_CNT, v);
        repeat (6) @(negedge clk);
        bus_read(A_CNT, v2);
        check(v2 == v, "R11 halted counter holds", v2, v);
        check(v != 0, "R11 counter nonzero before clear", v != 0, 1);
        bus_write(A_CTRL, 32'd7);
        repeat (2) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            bus_read(A_CNT, v);
            check(v == 0, "R11 clear holds counter at zero", v, 0);
        end

        // R9/R10 timer mode, set up while cleared
        bus_write(A_PRE, 0);
        bus_write(A_CTRL, 32'd4);
        bus_write(A_M0 + 4'd2, 1000);
        bus_write(A_M0 + 4'd3, 1000);
        bus_write(A_M0, 2);
        bus_write(A_M0 + 4'd1, 4);
        bus_read(A_M0 + 4'd1, v); check(v == 4, "R9 direct compare write", v, 4);
        bus_read(A_M0, v);        check(v == 2, "R9 direct compare 0 write", v, 2);
        bus_write(A_FLG, 32'hF);
        bus_read(A_FLG, v);       check(v == 0, "R10 flags cleared by write", v, 0);
        bus_write(A_CTRL, 32'd1);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            check(pwm_out == 0, "R9 outputs low in timer mode", {29'd0, pwm_out}, 0);
            bus_read(A_CNT, v);
            if (v >= 8) break;
        end
        check(v >= 8, "R9 counter passes compare 0", v, 8);
        bus_read(A_FLG, v); check(v == 32'h3, "R10 flags for compares 0 and 1", v, 3);
        bus_write(A_FLG, 32'h1);
        bus_read(A_FLG, v); check(v == 32'h2, "R10 write-one clears flag 0", v, 2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule